// File: doc/BRIEF.md
# Bus Status and Driver Enable Controller

This block sits between a processor core and its external bus pads. It turns the core's internal condition into a two-bit bus status code (a bus-available bit and a bus-state bit). It also decides, phase by phase within each bus cycle, whether the address and read/write pads may drive and whether write data may drive. The two clock phases E and Q arrive as level inputs and are sampled on a fast system clock. Q leads E. A bus cycle ends when E falls. The status code is loaded on the leading edge of Q and held for the rest of the cycle.

A three-state request lets another bus master take the pads. While it is asserted it removes the address and read/write enables at once. If it is still asserted when E rises, it is captured and keeps the pads released until the cycle ends. The status code itself is never released.

After the core gives up bus-available, the block keeps every driver off for a programmable number of dead cycles. This gives the other master time to get off the bus. A cycle in which the core needs no transfer is flagged to the pads, which then force all-ones on the address lines and a read on the direction line.

Top module: `busStatusTri`

## Requirements
- R1: The status pair {busAvail, busState} is 00 when the core state input is running (coreState 00 or 11), 01 for vector acknowledge (coreState 01), 10 for sync wait (coreState 10) and 11 when halted. Halt takes priority over sync, and sync over vector. The pair is loaded only at a leading edge of qClk and holds its value on every other clock.
- R2: When idleCycle is high at the Q leading edge, addrForceOnes and rwForceRead are high for that bus cycle, a vector acknowledge is reported as 00, and no write data is enabled.
- R3: addrDrvEn is low in any clock where busAvail is high or tscReq is high; tscReq acts with no delay.
- R4: If tscReq is high at the sample where eClk is first seen high, addrDrvEn and dataDrvEn stay low until eClk falls, even if tscReq drops first.
- R5: dataDrvEn rises only right after a Q leading edge, and only when writeCycle is high, idleCycle is low and tscReq is low at that edge. It falls when eClk falls.
- R6: tscReq never changes busAvail or busState, except as allowed by R7.
- R7: If tscReq is high at a Q leading edge where busAvail is low, busAvail is not raised, and the whole status pair keeps its previous value for that cycle.
- R8: When busAvail falls, both driver enables stay low until DEAD_CYCLES further falling edges of eClk have passed. With the default value of 1, this is the cycle in which busAvail fell.
- R9: A halt request becomes halted (11) only at a Q leading edge where instrEnd is high. It stays halted while haltReq stays high, and it leaves halted at the first Q leading edge with haltReq low.
- R10: If haltReq is high while rstN is low, the block leaves reset already in the halted state (11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus phases |
| rstN | input | 1 | Synchronous active-low reset |
| eClk | input | 1 | E bus phase, level |
| qClk | input | 1 | Q bus phase, level, leads E |
| tscReq | input | 1 | Three-state request from another bus master |
| haltReq | input | 1 | Halt request, active high |
| instrEnd | input | 1 | Core is at an instruction boundary |
| coreState | input | 2 | Core condition: 00 run, 01 vector, 10 sync, 11 run |
| writeCycle | input | 1 | Current bus cycle is a write |
| idleCycle | input | 1 | Current bus cycle needs no transfer |
| busAvail | output | 1 | Status bit: pads released to other masters |
| busState | output | 1 | Status bit qualifying busAvail |
| addrDrvEn | output | 1 | Address and read/write pad drive enable |
| dataDrvEn | output | 1 | Write data pad drive enable |
| addrForceOnes | output | 1 | Force the address lines to all ones |
| rwForceRead | output | 1 | Force the direction line to read |

## Verification
The three-state request is placed in four positions within a cycle: a pulse that ends before Q, a window that covers Q but ends before E, one that is held across the E rise, and one that starts only after E is high. Together these separate direct gating, capture at Q for write data, and capture at E. Read, write and idle cycles are crossed with these positions to show which enable each one touches. Sequences of sync, vector and halt states are applied with and without instruction boundaries and three-state requests. These show the status priority, the deferred rise of bus-available, the dead cycle after its fall, and halt entry during reset.

// File: rtl/busStatusPkg.sv
package busStatusPkg;

  // Status pair {busAvail, busState}
  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_VECTOR = 2'b01,
    ST_SYNC   = 2'b10,
    ST_HALT   = 2'b11
  } busCode_e;

  // Core condition input codes
  localparam logic [1:0] CORE_RUN    = 2'b00;
  localparam logic [1:0] CORE_VECTOR = 2'b01;
  localparam logic [1:0] CORE_SYNC   = 2'b10;

  // Strobes from control to datapath
  typedef struct packed {
    logic     qLead;     // Q leading edge seen this sample
    logic     eLead;     // E rising edge seen this sample
    logic     eTrail;    // E falling edge: bus cycle ends
    logic     haltNext;  // halted state to take at qLead
    logic     holdCode;  // keep previous status code at qLead
    busCode_e nextCode;  // candidate status code at qLead
  } phaseStb_t;

endpackage

// File: rtl/busPhaseCtrl.sv
module busPhaseCtrl
  import busStatusPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      eClk,
  input  logic      qClk,
  input  logic      tscReq,
  input  logic      haltReq,
  input  logic      instrEnd,
  input  logic [1:0] coreState,
  input  logic      idleCycle,
  input  logic      haltNow,
  input  logic      baNow,
  output phaseStb_t stb
);

  logic ePrev;
  logic qPrev;
  logic haltCand;
  busCode_e codeCand;

  // Sync reset copies the live phase levels so that no edge is seen
  // on the first sample after reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ePrev <= eClk;
      qPrev <= qClk;
    end else begin
      ePrev <= eClk;
      qPrev <= qClk;
    end
  end

  // Halt is entered at an instruction boundary and held while requested.
  always_comb begin
    haltCand = haltReq && (haltNow || instrEnd);
  end

  // Priority: halt > sync > vector > run; an idle cycle reports no vector.
  always_comb begin
    if (haltCand) begin
      codeCand = ST_HALT;
    end else if (coreState == CORE_SYNC) begin
      codeCand = ST_SYNC;
    end else if (coreState == CORE_VECTOR && !idleCycle) begin
      codeCand = ST_VECTOR;
    end else begin
      codeCand = ST_RUN;
    end
  end

  always_comb begin
    stb.qLead    = qClk && !qPrev;
    stb.eLead    = eClk && !ePrev;
    stb.eTrail   = !eClk && ePrev;
    stb.haltNext = haltCand;
    stb.nextCode = codeCand;
    // bus-available may not rise while another master holds the pads
    stb.holdCode = tscReq && !baNow && codeCand[1];
  end

endmodule

// File: rtl/busDrvPath.sv
module busDrvPath
  import busStatusPkg::*;
#(
  parameter int DEAD_CYCLES = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  phaseStb_t stb,
  input  logic      tscReq,
  input  logic      haltReq,
  input  logic      writeCycle,
  input  logic      idleCycle,
  output logic      haltNow,
  output logic      baNow,
  output busCode_e  code,
  output logic      addrDrvEn,
  output logic      dataDrvEn,
  output logic      idleNow
);

  localparam int DEAD_W = (DEAD_CYCLES < 1) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [DEAD_W-1:0] DEAD_LOAD = DEAD_W'(DEAD_CYCLES);

  logic              haltReg;
  busCode_e          codeReg;
  logic              tscHeld;
  logic              dataOpen;
  logic              idleReg;
  logic [DEAD_W-1:0] deadCnt;
  logic              deadBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltReg  <= haltReq;
      codeReg  <= haltReq ? ST_HALT : ST_RUN;
      tscHeld  <= 1'b0;
      dataOpen <= 1'b0;
      idleReg  <= 1'b0;
      deadCnt  <= '0;
    end else begin
      if (stb.eTrail) begin
        tscHeld  <= 1'b0;
        dataOpen <= 1'b0;
        if (deadCnt != '0) deadCnt <= deadCnt - 1'b1;
      end
      if (stb.eLead && tscReq) begin
        tscHeld <= 1'b1;
      end
      if (stb.qLead) begin
        haltReg  <= stb.haltNext;
        idleReg  <= idleCycle;
        dataOpen <= writeCycle && !idleCycle && !tscReq;
        if (!stb.holdCode) begin
          codeReg <= stb.nextCode;
          if (codeReg[1] && !stb.nextCode[1]) deadCnt <= DEAD_LOAD;
        end
      end
    end
  end

  always_comb begin
    deadBusy  = (deadCnt != '0);
    haltNow   = haltReg;
    baNow     = codeReg[1];
    code      = codeReg;
    idleNow   = idleReg;
    addrDrvEn = !codeReg[1] && !deadBusy && !tscReq && !tscHeld;
    dataDrvEn = dataOpen && !codeReg[1] && !deadBusy && !tscHeld;
  end

endmodule

// File: rtl/busStatusTri.sv
module busStatusTri
  import busStatusPkg::*;
#(
  parameter int DEAD_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eClk,
  input  logic       qClk,
  input  logic       tscReq,
  input  logic       haltReq,
  input  logic       instrEnd,
  input  logic [1:0] coreState,
  input  logic       writeCycle,
  input  logic       idleCycle,
  output logic       busAvail,
  output logic       busState,
  output logic       addrDrvEn,
  output logic       dataDrvEn,
  output logic       addrForceOnes,
  output logic       rwForceRead
);

  phaseStb_t stb;
  logic      haltNow;
  logic      baNow;
  busCode_e  code;
  logic      idleNow;

  busPhaseCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .eClk      (eClk),
    .qClk      (qClk),
    .tscReq    (tscReq),
    .haltReq   (haltReq),
    .instrEnd  (instrEnd),
    .coreState (coreState),
    .idleCycle (idleCycle),
    .haltNow   (haltNow),
    .baNow     (baNow),
    .stb       (stb)
  );

  busDrvPath #(.DEAD_CYCLES(DEAD_CYCLES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .tscReq     (tscReq),
    .haltReq    (haltReq),
    .writeCycle (writeCycle),
    .idleCycle  (idleCycle),
    .haltNow    (haltNow),
    .baNow      (baNow),
    .code       (code),
    .addrDrvEn  (addrDrvEn),
    .dataDrvEn  (dataDrvEn),
    .idleNow    (idleNow)
  );

  always_comb begin
    busAvail      = code[1];
    busState      = code[0];
    addrForceOnes = idleNow;
    rwForceRead   = idleNow;
  end

endmodule

// File: rtl/busStatusTriChk.sv
module busStatusTriChk (
  input logic clk,
  input logic rstN,
  input logic eClk,
  input logic qClk,
  input logic tscReq,
  input logic busAvail,
  input logic busState,
  input logic addrDrvEn,
  input logic dataDrvEn,
  input logic addrForceOnes
);

  // R1: status pair changes only after a Q leading edge
  a_r1_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(qClk) |=> $stable({busAvail, busState}));

  // R3: address enable off with bus-available or three-state request
  a_r3_addr_off: assert property (@(posedge clk) disable iff (!rstN)
    (busAvail || tscReq) |-> !addrDrvEn);

  // R4: request seen at E rise keeps the address pads released
  a_r4_tsc_capture: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(eClk) && tscReq) |=> (!addrDrvEn && !dataDrvEn));

  // R5: write data enable opens only right after a Q leading edge
  a_r5_data_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataDrvEn) |-> ($past(qClk, 1) && !$past(qClk, 2)));

  // R7: bus-available does not rise when a request is present at Q
  a_r7_ba_defer: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(qClk) && tscReq && !busAvail) |=> !busAvail);

  // R2: idle cycle never reports a vector acknowledge
  a_r2_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    (addrForceOnes && !busAvail) |-> !busState);

endmodule

bind busStatusTri busStatusTriChk chk (
  .clk           (clk),
  .rstN          (rstN),
  .eClk          (eClk),
  .qClk          (qClk),
  .tscReq        (tscReq),
  .busAvail      (busAvail),
  .busState      (busState),
  .addrDrvEn     (addrDrvEn),
  .dataDrvEn     (dataDrvEn),
  .addrForceOnes (addrForceOnes)
);

// File: tb/busStatusTri_test.sv
module busStatusTri_test;

  localparam int DEAD = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eClk = 1'b0, qClk = 1'b0, tscReq = 1'b0, haltReq = 1'b0;
  logic instrEnd = 1'b0, writeCycle = 1'b0, idleCycle = 1'b0;
  logic [1:0] coreState = 2'b00;
  logic busAvail, busState, addrDrvEn, dataDrvEn, addrForceOnes, rwForceRead;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  busStatusTri #(.DEAD_CYCLES(DEAD)) uut (
    .clk(clk), .rstN(rstN), .eClk(eClk), .qClk(qClk), .tscReq(tscReq),
    .haltReq(haltReq), .instrEnd(instrEnd), .coreState(coreState),
    .writeCycle(writeCycle), .idleCycle(idleCycle),
    .busAvail(busAvail), .busState(busState), .addrDrvEn(addrDrvEn),
    .dataDrvEn(dataDrvEn), .addrForceOnes(addrForceOnes),
    .rwForceRead(rwForceRead)
  );

  // Behavioural reference model, advanced on every rising clock
  int mHalt, mBa, mBs, mTsc, mDead, mData, mIdle, pE, pQ;
  always @(posedge clk) begin
    int h, cBa, cBs;
    if (!rstN) begin
      mHalt = haltReq; mBa = haltReq; mBs = haltReq;
      mTsc = 0; mDead = 0; mData = 0; mIdle = 0;
    end else begin
      if (!eClk && pE == 1) begin
        mTsc = 0; mData = 0;
        if (mDead > 0) mDead = mDead - 1;
      end
      if (eClk && pE == 0 && tscReq) mTsc = 1;
      if (qClk && pQ == 0) begin
        h = (haltReq && (mHalt == 1 || instrEnd)) ? 1 : 0;
        mHalt = h;
        if (h == 1) begin cBa = 1; cBs = 1; end
        else if (coreState == 2) begin cBa = 1; cBs = 0; end
        else if (coreState == 1 && !idleCycle) begin cBa = 0; cBs = 1; end
        else begin cBa = 0; cBs = 0; end
        if (!(tscReq && mBa == 0 && cBa == 1)) begin
          if (mBa == 1 && cBa == 0) mDead = DEAD;
          mBa = cBa; mBs = cBs;
        end
        mIdle = idleCycle;
        mData = (writeCycle && !idleCycle && !tscReq) ? 1 : 0;
      end
    end
    pE = eClk; pQ = qClk;
  end

  task automatic checkBit(input string what, input logic act, input int exp);
    testCount++;
    if (act !== exp[0]) begin
      failCount++;
      $display("FAIL %s %s act=%0b exp=%0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int expAddr, expData;
    expAddr = (mBa == 0 && mDead == 0 && !tscReq && mTsc == 0) ? 1 : 0;
    expData = (mData == 1 && mBa == 0 && mDead == 0 && mTsc == 0) ? 1 : 0;
    checkBit("busAvail", busAvail, mBa);
    checkBit("busState", busState, mBs);
    checkBit("addrDrvEn", addrDrvEn, expAddr);
    checkBit("dataDrvEn", dataDrvEn, expData);
    checkBit("addrForceOnes", addrForceOnes, mIdle);
    checkBit("rwForceRead", rwForceRead, mIdle);
  endtask

  // One bus cycle of 8 clocks: Q high on phases 2..5, E high on 4..7.
  // tscMode: 0 none, 1 phases 1..3, 2 phases 3..5, 3 phase 1, 4 phases 5..6
  task automatic busCycle(input bit wr, input bit idl, input logic [1:0] cs,
                          input bit hl, input bit ie, input int tscMode);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      compareAll();
      if (p == 0) begin
        writeCycle = wr; idleCycle = idl; coreState = cs;
        haltReq = hl; instrEnd = ie;
      end
      qClk = (p >= 2 && p <= 5);
      eClk = (p >= 4);
      case (tscMode)
        1: tscReq = (p >= 1 && p <= 3);
        2: tscReq = (p >= 3 && p <= 5);
        3: tscReq = (p == 1);
        4: tscReq = (p >= 5 && p <= 6);
        default: tscReq = 1'b0;
      endcase
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state: running code, address enabled, no data, no override
    curReq = "R1";
    @(negedge clk);
    checkBit("reset busAvail", busAvail, 0);
    checkBit("reset busState", busState, 0);
    checkBit("reset addrDrvEn", addrDrvEn, 1);
    checkBit("reset dataDrvEn", dataDrvEn, 0);
    // R1: each core state code
    busCycle(0, 0, 2'b00, 0, 1, 0);
    busCycle(0, 0, 2'b01, 0, 1, 0);
    busCycle(0, 0, 2'b11, 0, 1, 0);
    busCycle(0, 0, 2'b10, 0, 1, 0);
    busCycle(0, 0, 2'b10, 0, 1, 0);
    // R8: leaving sync gives a dead cycle
    curReq = "R8";
    busCycle(1, 0, 2'b00, 0, 1, 0);
    busCycle(1, 0, 2'b00, 0, 1, 0);
    // R2: idle cycles, with vector state and with a write flag
    curReq = "R2";
    busCycle(0, 1, 2'b00, 0, 1, 0);
    busCycle(1, 1, 2'b01, 0, 1, 0);
    busCycle(0, 0, 2'b01, 0, 1, 0);
    // R5: write versus read, and request held over Q
    curReq = "R5";
    busCycle(1, 0, 2'b00, 0, 1, 0);
    busCycle(0, 0, 2'b00, 0, 1, 0);
    busCycle(1, 0, 2'b00, 0, 1, 1);
    busCycle(1, 0, 2'b00, 0, 1, 3);
    // R3: direct gating before Q and after E rise
    curReq = "R3";
    busCycle(0, 0, 2'b00, 0, 1, 1);
    busCycle(1, 0, 2'b00, 0, 1, 4);
    busCycle(0, 0, 2'b00, 0, 1, 3);
    // R4: request held across E rise is captured
    curReq = "R4";
    busCycle(1, 0, 2'b00, 0, 1, 2);
    busCycle(0, 0, 2'b00, 0, 1, 2);
    busCycle(1, 0, 2'b00, 0, 1, 0);
    // R7: sync requested while request present at Q is deferred
    curReq = "R7";
    busCycle(0, 0, 2'b10, 0, 1, 1);
    busCycle(0, 0, 2'b10, 0, 1, 0);
    // R6: request while already released leaves status alone
    curReq = "R6";
    busCycle(0, 0, 2'b10, 0, 1, 2);
    busCycle(0, 0, 2'b01, 0, 1, 1);
    busCycle(0, 0, 2'b01, 0, 1, 2);
    curReq = "R8";
    busCycle(1, 0, 2'b00, 0, 1, 0);
    // R9: no halt without instruction boundary, then halt, then release
    curReq = "R9";
    busCycle(0, 0, 2'b00, 1, 0, 0);
    busCycle(0, 0, 2'b00, 1, 0, 0);
    busCycle(0, 0, 2'b00, 1, 1, 0);
    busCycle(0, 0, 2'b10, 1, 0, 0);
    busCycle(1, 0, 2'b01, 1, 0, 2);
    busCycle(0, 0, 2'b00, 0, 0, 0);
    busCycle(0, 0, 2'b00, 0, 1, 0);
    // R10: halt asserted during reset
    curReq = "R10";
    @(negedge clk);
    rstN = 1'b0; haltReq = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkBit("halt after reset busAvail", busAvail, 1);
    checkBit("halt after reset busState", busState, 1);
    busCycle(0, 0, 2'b00, 1, 0, 0);
    busCycle(0, 0, 2'b00, 0, 0, 0);
    busCycle(1, 0, 2'b00, 0, 1, 0);
    @(negedge clk);
    compareAll();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule